// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a single-channel SPI master that moves one serial word for each accepted command. Two configuration registers, written through a simple write port, set the clock polarity, the clock phase, the word length, the serial clock divisor, the output drive mode, an engine enable and two delay lengths. A command carries the word to send, a chip-select pattern and two flags. One flag inserts a programmable wait between chip-select assertion and the first clock edge. The other inserts a programmable wait after the last bit.

The engine is a five-state machine. **IDLE** waits for a command, with the chip selects inactive and SCK at its rest level. IDLE→**LEAD** is taken on command acceptance. LEAD counts the lead delay. LEAD→**SHIFT** is taken when that count expires. SHIFT toggles SCK and moves the data bits. SHIFT→**POST** is taken after the final edge when the command's post flag is set, and SHIFT→**FIN** is taken when it is clear. POST→FIN is taken when the post delay expires. FIN→IDLE follows one cycle later, and FIN is the cycle in which the done strobe is raised. From any state, clearing the enable bit forces a return to IDLE.

The received word appears right-aligned with the done strobe. The chip-select pattern is held from acceptance until the done cycle.

Top module: `spi_xfer_engine`

## Requirements
- R1: While the enable bit (control register bit 15) is clear, including after reset, every output enable is low, `cmd_ready` is low and `done` stays low. Clearing enable during a transfer abandons it with no done strobe.
- R2: SCK rests at CPOL (mode register bit 9) whenever no transfer runs. A divisor (mode bits 7:0) of 0 or 1 keeps SCK at CPOL and refuses commands.
- R3: During SHIFT, SCK toggles once every D system clocks, where D is the divisor, so one bit takes 2·D clocks.
- R4: The word length N comes from mode bits 13:10. A value of 0 gives 16, values 8 to 15 give themselves, and values 1 to 7 give 8. Bits move MSB first.
- R5: With CPHA (mode bit 8) at 0, MOSI holds the first bit from acceptance, MISO is sampled on each leading SCK edge, and MOSI changes on trailing edges.
- R6: With CPHA at 1, MOSI changes on each leading edge and MISO is sampled on each trailing edge.
- R7: With `cmd_lead_en` set, the lead wait L is the lead field (control bits 14:8) in clocks, and a field of 0 means 128. With the flag clear, L is D.
- R8: With `cmd_post_en` set, the post wait P is 32 times the post field (control bits 7:0), and a field of 0 means 8192 clocks. With the flag clear, P is 0.
- R9: `cs_o` carries the command pattern from the cycle after acceptance through the done cycle. At all other times it is all ones.
- R10: `done` is high for exactly one cycle, L + 2·N·D + P clock edges after the accepting edge. `rx_data` then holds the N received bits right-aligned.
- R11: With wired-OR mode (mode bit 15) set, an output enable is high only while that output is low. With the mode clear and the engine enabled, every output enable is high.
- R12: `cmd_ready` is high only in IDLE with the engine enabled and the divisor at 2 or more. It drops in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mode register, 1 selects the control register |
| cfg_wdata | input | 16 | Configuration write data |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_data | input | 16 | Word to transmit, right-aligned |
| cmd_cs | input | NCS | Chip-select pattern for this transfer |
| cmd_lead_en | input | 1 | Apply the programmed lead wait |
| cmd_post_en | input | 1 | Apply the programmed post wait |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out value |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select values |
| cs_oe | output | NCS | Chip-select output enables |
| done | output | 1 | One-cycle completion strobe |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
Counting from the edge that accepts a command, the done strobe is due after exactly L + 2·N·D + P further rising edges. The chip selects take the pattern one edge after acceptance and fall back to all ones one edge after done. The bench drives inputs and samples outputs only on falling edges, and it counts rising edges from acceptance so that each result is compared in the one cycle where it is due. The bench also acts as a slave that follows SCK edges from its pin view, so it checks the sampling and launch edges of both phases without looking inside the design.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int WORD_W = 16;
    localparam int CFG_W  = 16;
    localparam int DIV_W  = 8;
    localparam int LEAD_W = 7;
    localparam int POST_W = 8;
    localparam int BITS_W = 4;
    localparam int NB_W   = $clog2(WORD_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_POST,
        ST_FIN
    } xfer_state_e;

    typedef struct packed {
        logic              wired_or;
        logic              cpol;
        logic              cpha;
        logic [BITS_W-1:0] bits;
        logic [DIV_W-1:0]  divisor;
    } mode_cfg_t;

    typedef struct packed {
        logic              enable;
        logic [LEAD_W-1:0] lead;
        logic [POST_W-1:0] post;
    } ctrl_cfg_t;

    function automatic logic [NB_W-1:0] word_len(input logic [BITS_W-1:0] f);
        if (f == '0)
            return NB_W'(WORD_W);
        else if (f < BITS_W'(8))
            return NB_W'(8);
        else
            return NB_W'(f);
    endfunction

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output mode_cfg_t        mode,
    output ctrl_cfg_t        ctrl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode.wired_or <= 1'b0;
            mode.cpol     <= 1'b0;
            mode.cpha     <= 1'b1;
            mode.bits     <= '0;
            mode.divisor  <= DIV_W'(4);
        end else if (we && !sel) begin
            mode.wired_or <= wdata[15];
            mode.cpol     <= wdata[9];
            mode.cpha     <= wdata[8];
            mode.bits     <= wdata[13:10];
            mode.divisor  <= wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl.enable <= 1'b0;
            ctrl.lead   <= LEAD_W'(4);
            ctrl.post   <= POST_W'(4);
        end else if (we && sel) begin
            ctrl.enable <= wdata[15];
            ctrl.lead   <= wdata[14:8];
            ctrl.post   <= wdata[7:0];
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W    = 16,
    parameter int NB_W = $clog2(W) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    load_data,
    input  logic [NB_W-1:0] nbits,
    input  logic            shift_en,
    input  logic            sample_en,
    input  logic            miso,
    output logic            mosi,
    output logic [W-1:0]    rx_word
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // transmit register: the word is left-aligned so the MSB of the word is on top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_data << (W - int'(nbits));
        else if (shift_en)
            tx_q <= {tx_q[W-2:0], 1'b0};
    end

    // receive register: cleared on load, bits enter at the bottom
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= '0;
        else if (load)
            rx_q <= '0;
        else if (sample_en)
            rx_q <= {rx_q[W-2:0], miso};
    end

    assign mosi    = tx_q[W-1];
    assign rx_word = rx_q;

endmodule

// File: rtl/spi_pin_drive.sv
module spi_pin_drive #(
    parameter int N = 6
) (
    input  logic         en,
    input  logic         wired,
    input  logic [N-1:0] val,
    output logic [N-1:0] pin_o,
    output logic [N-1:0] pin_oe
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign pin_o[g]  = val[g];
        assign pin_oe[g] = en & (~wired | ~val[g]);
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int NCS       = 4,
    parameter int POST_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [NCS-1:0]    cmd_cs,
    input  logic              cmd_lead_en,
    input  logic              cmd_post_en,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic [NCS-1:0]    cs_o,
    output logic [NCS-1:0]    cs_oe,
    output logic              done,
    output logic [WORD_W-1:0] rx_data
);

    localparam int CNT_W  = $clog2(POST_UNIT * (2 ** POST_W)) + 1;
    localparam int EDGE_W = $clog2(2 * WORD_W) + 1;
    localparam int NPIN   = NCS + 2;

    mode_cfg_t   mode;
    ctrl_cfg_t   ctrl;
    xfer_state_e state, nxt;

    logic [CNT_W-1:0]  cnt;
    logic [EDGE_W-1:0] edge_idx;
    logic [EDGE_W-1:0] last_idx;
    logic [NB_W-1:0]   nbits_q;
    logic [NCS-1:0]    cs_q;
    logic              post_en_q;
    logic              sck_q;

    logic [CNT_W-1:0]  lead_span;
    logic [CNT_W-1:0]  post_span;
    logic [CNT_W-1:0]  div_span;
    logic              clk_on;
    logic              accept;
    logic              tick;
    logic              leading;
    logic              last_edge;
    logic              shift_en;
    logic              sample_en;
    logic              tx_bit;

    logic              sck_val;
    logic              mosi_val;
    logic [NCS-1:0]    cs_val;
    logic [NPIN-1:0]   pin_val;
    logic [NPIN-1:0]   pin_o;
    logic [NPIN-1:0]   pin_oe;

    spi_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .mode  (mode),
        .ctrl  (ctrl)
    );

    // derived timing values
    always_comb begin
        div_span  = CNT_W'(mode.divisor);
        lead_span = (ctrl.lead == '0) ? CNT_W'(1 << LEAD_W) : CNT_W'(ctrl.lead);
        post_span = ((ctrl.post == '0) ? CNT_W'(1 << POST_W) : CNT_W'(ctrl.post))
                    * CNT_W'(POST_UNIT);
        clk_on    = (mode.divisor >= DIV_W'(2));
        last_idx  = EDGE_W'({nbits_q, 1'b0}) - EDGE_W'(1);
        tick      = (cnt == CNT_W'(1));
        leading   = ~edge_idx[0];
        last_edge = (edge_idx == last_idx);
    end

    assign cmd_ready = (state == ST_IDLE) && ctrl.enable && clk_on;
    assign accept    = cmd_valid && cmd_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) nxt = post_en_q ? ST_POST : ST_FIN;
            ST_POST:  if (tick) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!ctrl.enable)
            nxt = ST_IDLE;
    end

    // counters, serial clock and latched command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            edge_idx  <= '0;
            sck_q     <= 1'b0;
            cs_q      <= '1;
            post_en_q <= 1'b0;
            nbits_q   <= NB_W'(WORD_W);
        end else if (accept) begin
            cnt       <= cmd_lead_en ? lead_span : div_span;
            edge_idx  <= '0;
            sck_q     <= mode.cpol;
            cs_q      <= cmd_cs;
            post_en_q <= cmd_post_en;
            nbits_q   <= word_len(mode.bits);
        end else begin
            unique case (state)
                ST_LEAD: cnt <= tick ? div_span : cnt - CNT_W'(1);
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q    <= ~sck_q;
                        edge_idx <= edge_idx + EDGE_W'(1);
                        cnt      <= last_edge ? post_span : div_span;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_POST: cnt <= cnt - CNT_W'(1);
                ST_IDLE, ST_FIN: cnt <= cnt;
                default: cnt <= cnt;
            endcase
        end
    end

    // data movement: phase decides which edge samples and which launches
    always_comb begin
        sample_en = (state == ST_SHIFT) && tick && (leading ^ mode.cpha);
        if (mode.cpha)
            shift_en = (state == ST_SHIFT) && tick && leading && (edge_idx != '0);
        else
            shift_en = (state == ST_SHIFT) && tick && !leading && !last_edge;
    end

    spi_shifter #(.W(WORD_W), .NB_W(NB_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (cmd_data),
        .nbits     (word_len(mode.bits)),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso_i),
        .mosi      (tx_bit),
        .rx_word   (rx_data)
    );

    // outputs by state
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                sck_val  = mode.cpol;
                mosi_val = 1'b1;
                cs_val   = '1;
                done     = 1'b0;
            end
            ST_FIN: begin
                sck_val  = sck_q;
                mosi_val = tx_bit;
                cs_val   = cs_q;
                done     = 1'b1;
            end
            default: begin
                sck_val  = sck_q;
                mosi_val = tx_bit;
                cs_val   = cs_q;
                done     = 1'b0;
            end
        endcase
        pin_val = {sck_val, mosi_val, cs_val};
    end

    spi_pin_drive #(.N(NPIN)) u_pins (
        .en     (ctrl.enable),
        .wired  (mode.wired_or),
        .val    (pin_val),
        .pin_o  (pin_o),
        .pin_oe (pin_oe)
    );

    assign sck_o   = pin_o[NPIN-1];
    assign sck_oe  = pin_oe[NPIN-1];
    assign mosi_o  = pin_o[NPIN-2];
    assign mosi_oe = pin_oe[NPIN-2];
    assign cs_o    = pin_o[NCS-1:0];
    assign cs_oe   = pin_oe[NCS-1:0];

    // R10: completion strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: a cleared enable always brings the machine back to idle
    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |=> state == ST_IDLE);

    // R12: an accepted command makes the engine busy
    p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2: after an even number of toggles the clock is back at rest
    p_sck_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |-> (sck_q == mode.cpol));

    // R9: chip selects do not move inside a transfer
    p_cs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cs_o));

    // R4: the edge count never passes 2N-1 while shifting
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (edge_idx <= last_idx));

endmodule

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NV         = 6;

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [3:0]  bits;
        logic [7:0]  div;
        logic        lead_en;
        logic [6:0]  lead;
        logic        post_en;
        logic [7:0]  post;
        logic        wired;
        logic [15:0] data;
        logic [15:0] pat;
        logic [3:0]  cs;
        logic [4:0]  exp_n;
        logic [15:0] exp_t;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{cpol:1'b0, cpha:1'b0, bits:4'd8,  div:8'd2,   lead_en:1'b0, lead:7'd0, post_en:1'b0, post:8'd0,
          wired:1'b0, data:16'h00A5, pat:16'h003C, cs:4'hE, exp_n:5'd8,  exp_t:16'd34},
        '{cpol:1'b1, cpha:1'b1, bits:4'd0,  div:8'd3,   lead_en:1'b1, lead:7'd5, post_en:1'b0, post:8'd0,
          wired:1'b0, data:16'h1234, pat:16'hBEEF, cs:4'hD, exp_n:5'd16, exp_t:16'd101},
        '{cpol:1'b0, cpha:1'b1, bits:4'd12, div:8'd4,   lead_en:1'b1, lead:7'd0, post_en:1'b1, post:8'd2,
          wired:1'b0, data:16'h0ABC, pat:16'hF0F5, cs:4'hB, exp_n:5'd12, exp_t:16'd288},
        '{cpol:1'b1, cpha:1'b0, bits:4'd3,  div:8'd2,   lead_en:1'b0, lead:7'd0, post_en:1'b1, post:8'd0,
          wired:1'b1, data:16'h01C3, pat:16'h015A, cs:4'h7, exp_n:5'd8,  exp_t:16'd8226},
        '{cpol:1'b0, cpha:1'b0, bits:4'd15, div:8'd255, lead_en:1'b1, lead:7'd1, post_en:1'b1, post:8'd1,
          wired:1'b0, data:16'h7FFF, pat:16'h4001, cs:4'h0, exp_n:5'd15, exp_t:16'd7683},
        '{cpol:1'b1, cpha:1'b1, bits:4'd9,  div:8'd2,   lead_en:1'b0, lead:7'd0, post_en:1'b0, post:8'd0,
          wired:1'b0, data:16'hF1FF, pat:16'h00AA, cs:4'h5, exp_n:5'd9,  exp_t:16'd38}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic [3:0]  cmd_cs = 4'hF;
    logic        cmd_lead_en = 1'b0;
    logic        cmd_post_en = 1'b0;
    logic        sck_o, sck_oe, mosi_o, mosi_oe;
    logic [3:0]  cs_o, cs_oe;
    logic        done;
    logic [15:0] rx_data;

    logic [16:0] slv_tx = '0;
    logic [15:0] slv_cap = '0;
    logic        slv_prev = 1'b0;
    int          errors = 0;
    int          checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_xfer_engine u_spi_xfer_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_data    (cmd_data),
        .cmd_cs      (cmd_cs),
        .cmd_lead_en (cmd_lead_en),
        .cmd_post_en (cmd_post_en),
        .sck_o       (sck_o),
        .sck_oe      (sck_oe),
        .mosi_o      (mosi_o),
        .mosi_oe     (mosi_oe),
        .miso_i      (slv_tx[16]),
        .cs_o        (cs_o),
        .cs_oe       (cs_oe),
        .done        (done),
        .rx_data     (rx_data)
    );

    // pins seen through a pull-up
    function automatic logic pin1(input logic o, input logic oe);
        return oe ? o : 1'b1;
    endfunction

    function automatic logic [3:0] cs_pins();
        return cs_o | ~cs_oe;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // slave view at a falling edge: react to any SCK change on the pin
    task automatic slave_step(input logic cpol, input logic cpha);
        logic sp;
        sp = pin1(sck_o, sck_oe);
        if (sp != slv_prev) begin
            if ((slv_prev == cpol) ^ cpha)
                slv_cap = {slv_cap[14:0], pin1(mosi_o, mosi_oe)};
            else
                slv_tx = {slv_tx[15:0], 1'b0};
        end
        slv_prev = sp;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [15:0] mask;
        logic [15:0] al;
        int          t;
        bit          seen;
        bit          cs_ok;
        mask = 16'((32'h1 << v.exp_n) - 1);
        wr(1'b0, {v.wired, 1'b0, v.bits, v.cpol, v.cpha, v.div});
        wr(1'b1, {1'b1, v.lead, v.post});
        al       = v.pat << (16 - int'(v.exp_n));
        slv_tx   = v.cpha ? {1'b0, al} : {al, 1'b0};
        slv_cap  = '0;
        slv_prev = v.cpol;
        @(negedge clk);
        chk(cmd_ready === 1'b1, $sformatf("R12 ready before vec %0d", idx), 32'(cmd_ready), 1);
        cmd_valid   = 1'b1;
        cmd_data    = v.data;
        cmd_cs      = v.cs;
        cmd_lead_en = v.lead_en;
        cmd_post_en = v.post_en;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        t     = 0;
        seen  = 1'b0;
        cs_ok = (cs_pins() == v.cs);
        while (!seen && t < 20000) begin
            @(posedge clk);
            t++;
            @(negedge clk);
            slave_step(v.cpol, v.cpha);
            if (cs_pins() != v.cs) cs_ok = 1'b0;
            if (done === 1'b1) seen = 1'b1;
        end
        // R3 R7 R8 R10: done edge count
        chk(seen && t == int'(v.exp_t), $sformatf("R10 R3 R7 R8 done timing vec %0d", idx), 32'(t), 32'(v.exp_t));
        chk(rx_data == (v.pat & mask), $sformatf("R4 R5 R6 rx word vec %0d", idx), 32'(rx_data), 32'(v.pat & mask));
        chk(slv_cap == (v.data & mask), $sformatf("R4 R5 R6 mosi word vec %0d", idx), 32'(slv_cap), 32'(v.data & mask));
        chk(cs_ok, $sformatf("R9 cs held vec %0d", idx), 32'(cs_pins()), 32'(v.cs));
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, $sformatf("R10 one-cycle done vec %0d", idx), 32'(done), 0);
        chk(cs_pins() == 4'hF, $sformatf("R9 cs released vec %0d", idx), 32'(cs_pins()), 32'hF);
        chk(pin1(sck_o, sck_oe) == v.cpol, $sformatf("R2 sck rest vec %0d", idx), 32'(sck_o), 32'(v.cpol));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got_done;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({sck_oe, mosi_oe, cs_oe} == 6'b0, "R1 oe in reset", 32'({sck_oe, mosi_oe, cs_oe}), 0);
        chk(cmd_ready === 1'b0 && done === 1'b0, "R1 ready/done in reset", 32'({cmd_ready, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sck_oe, mosi_oe, cs_oe} == 6'b0, "R1 oe disabled after reset", 32'({sck_oe, mosi_oe, cs_oe}), 0);
        chk(cmd_ready === 1'b0, "R1 ready disabled", 32'(cmd_ready), 0);

        // R11 R2 R9: push-pull idle
        wr(1'b0, {1'b0, 1'b0, 4'd8, 1'b1, 1'b0, 8'd4});
        wr(1'b1, {1'b1, 7'd4, 8'd4});
        @(negedge clk);
        chk({sck_oe, mosi_oe, cs_oe} == 6'h3F, "R11 push-pull oe", 32'({sck_oe, mosi_oe, cs_oe}), 32'h3F);
        chk(sck_o == 1'b1 && cs_o == 4'hF, "R2 R9 idle levels cpol1", 32'({sck_o, cs_o}), 32'h1F);

        // R2 R12: divisor 1 and 0 stop the clock
        wr(1'b0, {1'b0, 1'b0, 4'd8, 1'b1, 1'b0, 8'd1});
        @(negedge clk);
        chk(cmd_ready === 1'b0, "R2 R12 divisor 1 refuses", 32'(cmd_ready), 0);
        chk(pin1(sck_o, sck_oe) == 1'b1, "R2 divisor 1 sck at cpol", 32'(sck_o), 1);
        wr(1'b0, {1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 8'd0});
        cmd_valid = 1'b1;
        cmd_cs    = 4'h0;
        got_done  = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done === 1'b1 || pin1(sck_o, sck_oe) != 1'b0 || cs_pins() != 4'hF) got_done = 1'b1;
        end
        cmd_valid = 1'b0;
        chk(!got_done, "R2 divisor 0 no activity", 32'(got_done), 0);

        // R11: open-drain idle
        wr(1'b0, {1'b1, 1'b0, 4'd8, 1'b0, 1'b0, 8'd4});
        @(negedge clk);
        chk({sck_oe, mosi_oe, cs_oe} == 6'b100000, "R11 wired idle oe", 32'({sck_oe, mosi_oe, cs_oe}), 32'h20);

        // main vector walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1: abandon a transfer by clearing enable
        wr(1'b0, {1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 8'd2});
        wr(1'b1, {1'b1, 7'd0, 8'd1});
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_cs      = 4'hA;
        cmd_lead_en = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cs_pins() == 4'hA, "R9 cs after accept", 32'(cs_pins()), 32'hA);
        repeat (8) @(negedge clk);
        wr(1'b1, {1'b0, 7'd0, 8'd1});
        got_done = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done === 1'b1) got_done = 1'b1;
        end
        chk(!got_done, "R1 abandoned transfer gives no done", 32'(got_done), 0);
        chk({sck_oe, mosi_oe, cs_oe} == 6'b0, "R1 oe after abandon", 32'({sck_oe, mosi_oe, cs_oe}), 0);
        wr(1'b1, {1'b1, 7'd0, 8'd1});
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R1 R12 ready after re-enable", 32'(cmd_ready), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule